// File: doc/BRIEF.md
# Best-Matched Pair Tournament Selector

This controller runs once after power-up to choose, from a bank of nominally identical analog device pairs, the one with the smallest mismatch. It holds two candidates in slots A and B and places them in an external offset-comparison cell. It then measures the comparator twice: once with the slot B pair at normal polarity, and once with that pair's polarity inverted. A stored copy of the first reading is XORed with the second. If the reading flipped, the inverted pair dominates the combined offset and is dropped. Otherwise the slot A pair is dropped. The freed slot takes the lowest-numbered pair not yet used.

When no unused pairs remain, the last comparison fixes the survivor. Its index appears on the winner output, slot A is parked on it, and done rises. The settling wait before each comparator sample comes from an input, so one netlist can serve comparators of different speeds. The comparator, the switches and the offset sensing sit outside the block.

Top module: `tsel_top`

## Requirements
- R1: A start pulse while idle begins a run. On the next clock slot A shows pair 0, slot B shows pair 1 and the swap control is 0. Once a run has finished, the winner output and slot A hold their values until the next accepted start.
- R2: While a run is in progress, slots A and B always carry different pair indices.
- R3: Replacement pairs are taken from the bank in ascending index order, starting at 2. Each index is used at most once per run, and only the slot that lost is reloaded.
- R4: Each comparison has a first phase with swap 0 and a second phase with swap 1. Swap returns to 0 when the second phase ends.
- R5: After every change of slot selection or swap, the comparator input is sampled on the clock edge that ends the (settle_len+1)-th cycle of that phase. Swap is therefore high for exactly settle_len+1 cycles.
- R6: The comparator reading from the first phase is kept. If the second reading differs from it, the slot B pair loses. If the two readings are equal, the slot A pair loses.
- R7: done rises after exactly NUM_PAIRS-1 comparisons. At that point winner equals the surviving pair's index and slot A equals winner.
- R8: start is ignored while a run is in progress.
- R9: A synchronous active-high reset gives winner 0, done 0, both slots 0, swap 0, and leaves the controller idle.
- R10: A start pulse after a finished run begins a new run and clears done on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection run (accepted only when idle) |
| settle_len | input | CNT_W | Settling cycles added before each comparator sample; hold stable during a run |
| cmp_in | input | 1 | Comparator decision from the offset-comparison cell |
| sel_a | output | IDX_W | Pair index connected to slot A |
| sel_b | output | IDX_W | Pair index connected to slot B |
| swap_b | output | 1 | Inverts the polarity of the slot B pair's offset |
| winner | output | IDX_W | Index of the surviving pair |
| done | output | 1 | Selection finished; winner is valid |

## Verification
The bench drives four offset banks. In these banks the smallest-magnitude pair sits at a middle index, at the last index, at index 0 and at index 3. The signs are mixed so that a flipped reading occurs for both positive and negative dominant offsets, and this separates a correct XOR verdict from an inverted one. Settling lengths of 0, 1, 2 and 5 are used. The modelled comparator returns the wrong answer until the configured wait has passed, so a sample taken one cycle early corrupts the result. One run carries a start pulse in mid-run, and another restarts after a finished run, which shows the difference between ignored and accepted starts.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_MEAS_UP = 2'd1,
    ST_MEAS_DN = 2'd2
  } tsel_state_e;
endpackage

// File: rtl/tsel_settle_timer.sv
module tsel_settle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && cnt != limit) cnt <= cnt + 1'b1;
  end

  // R5: the counter never climbs past the limit while the limit holds still
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && $stable(limit) && cnt <= limit) |=> (cnt <= limit));
endmodule

// File: rtl/tsel_pair_pool.sv
module tsel_pair_pool #(
  parameter int NUM_PAIRS = 8,
  parameter int IDX_W     = $clog2(NUM_PAIRS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             take,
  output logic [IDX_W-1:0] next_idx,
  output logic             empty
);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] FIRST_FREE = PTR_W'(2);
  localparam logic [PTR_W-1:0] LIMIT      = PTR_W'(NUM_PAIRS);

  logic [PTR_W-1:0] ptr;

  assign next_idx = ptr[IDX_W-1:0];
  assign empty    = (ptr >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst)                ptr <= FIRST_FREE;
    else if (load)          ptr <= FIRST_FREE;
    else if (take && !empty) ptr <= ptr + 1'b1;
  end

  // R3: the pointer only moves forward inside a run and never passes the bank end
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (rst)
    ptr <= LIMIT);
  p_ptr_forward_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !take) |=> $stable(ptr));
endmodule

// File: rtl/tsel_verdict.sv
module tsel_verdict (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic cmp_in,
  output logic flipped
);
  logic ref_q;

  always_ff @(posedge clk) begin
    if (rst)          ref_q <= 1'b0;
    else if (capture) ref_q <= cmp_in;
  end

  assign flipped = ref_q ^ cmp_in;
endmodule

// File: rtl/tsel_top.sv
module tsel_top #(
  parameter int NUM_PAIRS = 8,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = $clog2(NUM_PAIRS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] settle_len,
  input  logic             cmp_in,
  output logic [IDX_W-1:0] sel_a,
  output logic [IDX_W-1:0] sel_b,
  output logic             swap_b,
  output logic [IDX_W-1:0] winner,
  output logic             done
);
  import tsel_pkg::*;

  tsel_state_e      state;
  logic             expired, flipped, empty;
  logic             load, take, capture, tmr_clr, tmr_run;
  logic [IDX_W-1:0] next_idx, survivor;

  assign load     = (state == ST_IDLE) && start;
  assign capture  = (state == ST_MEAS_UP) && expired;
  assign take     = (state == ST_MEAS_DN) && expired && !empty;
  assign tmr_clr  = load || expired;
  assign tmr_run  = (state != ST_IDLE);
  assign survivor = flipped ? sel_a : sel_b;

  tsel_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run),
    .limit(settle_len), .expired(expired)
  );

  tsel_pair_pool #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_pool (
    .clk(clk), .rst(rst), .load(load), .take(take),
    .next_idx(next_idx), .empty(empty)
  );

  tsel_verdict u_verdict (
    .clk(clk), .rst(rst), .capture(capture), .cmp_in(cmp_in), .flipped(flipped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sel_a  <= '0;
      sel_b  <= '0;
      swap_b <= 1'b0;
      winner <= '0;
      done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          sel_a  <= '0;
          sel_b  <= IDX_W'(1);
          swap_b <= 1'b0;
          done   <= 1'b0;
          state  <= ST_MEAS_UP;
        end
        ST_MEAS_UP: if (expired) begin
          swap_b <= 1'b1;
          state  <= ST_MEAS_DN;
        end
        ST_MEAS_DN: if (expired) begin
          swap_b <= 1'b0;
          if (empty) begin
            winner <= survivor;
            sel_a  <= survivor;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            if (flipped) sel_b <= next_idx;
            else         sel_a <= next_idx;
            state <= ST_MEAS_UP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the two candidate slots never point at the same pair during a run
  p_slots_distinct_r2: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (sel_a != sel_b));
  // R4: polarity swap only during the second measurement phase
  p_swap_phase_r4: assert property (@(posedge clk) disable iff (rst)
    swap_b |-> (state == ST_MEAS_DN));
  // R7: done is only ever shown while the controller is idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE));
  // R1: the chosen pair is held while idle without a start
  p_hold_winner_r1: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !start) |=> ($stable(winner) && $stable(sel_a)));
  // R8: a start during a run does not restart the bank
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_MEAS_UP) && !expired) |=> ($stable(sel_a) && $stable(sel_b)));
endmodule

// File: tb/sim_tsel_top.sv
module sim_tsel_top;
  localparam int N  = 8;
  localparam int CW = 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] settle = '0;
  logic cmp = 1'b0;
  logic [IW-1:0] sel_a, sel_b, winner;
  logic swap_b, done;

  always #5 clk = ~clk;

  tsel_top #(.NUM_PAIRS(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .settle_len(settle), .cmp_in(cmp),
    .sel_a(sel_a), .sel_b(sel_b), .swap_b(swap_b), .winner(winner), .done(done)
  );

  int off[N];
  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ph = 0, m_cnt = 0, m_a = 0, m_b = 0, m_win = 0;
  bit m_swap = 0, m_done = 0, m_latch = 0;
  int m_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_a = 0; m_b = 0; m_swap = 0; m_done = 0; m_win = 0; m_cnt = 0;
    end else begin
      case (m_ph)
        0: if (start) begin
          m_a = 0; m_b = 1; m_swap = 0; m_done = 0; m_ph = 1; m_cnt = 0;
          m_q.delete();
          for (int i = 2; i < N; i++) m_q.push_back(i);
        end
        1: if (m_cnt == int'(settle)) begin
          m_latch = cmp; m_ph = 2; m_cnt = 0; m_swap = 1;
        end else m_cnt++;
        default: if (m_cnt == int'(settle)) begin
          bit chg;
          chg = m_latch ^ cmp;
          m_swap = 0; m_cnt = 0;
          if (m_q.size() == 0) begin
            m_win = chg ? m_a : m_b;
            m_a = m_win; m_done = 1; m_ph = 0;
          end else begin
            if (chg) m_b = m_q.pop_front();
            else     m_a = m_q.pop_front();
            m_ph = 1;
          end
        end else m_cnt++;
      endcase
    end
  end

  // per-clock comparison, monitors, and the comparator model
  int age = 0, pa = -1, pb = -1, ps = -1, hi = 0, ncmp = 0;
  bit pdone = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(sel_a) == m_a, "R3 slot A", sel_a, m_a);
      chk(int'(sel_b) == m_b, "R3 slot B", sel_b, m_b);
      chk(swap_b == m_swap, "R4 swap", swap_b, m_swap);
      chk(done == m_done, "R7 done", done, m_done);
      chk(int'(winner) == m_win, "R7 winner", winner, m_win);
      if (m_ph != 0) chk(sel_a != sel_b, "R2 distinct slots", sel_a, sel_b);
      if (swap_b) hi++;
      else if (hi > 0) begin
        chk(hi == int'(settle) + 1, "R5 swap phase length", hi, int'(settle) + 1);
        hi = 0;
        ncmp++;
      end
      if (done && !pdone) chk(ncmp == N - 1, "R7 comparison count", ncmp, N - 1);
      pdone = done;
    end else begin
      hi = 0; pdone = 0;
    end
    if (int'(sel_a) != pa || int'(sel_b) != pb || int'(swap_b) != ps) age = 0;
    else if (age < 100) age++;
    pa = sel_a; pb = sel_b; ps = swap_b;
    begin
      int sum;
      bit truth;
      sum = off[sel_a] + (swap_b ? -off[sel_b] : off[sel_b]);
      truth = (sum > 0);
      cmp = (age >= int'(settle)) ? truth : !truth;
    end
  end

  function automatic int best_idx();
    int b = 0;
    for (int i = 1; i < N; i++) begin
      int x, y;
      x = (off[i] < 0) ? -off[i] : off[i];
      y = (off[b] < 0) ? -off[b] : off[b];
      if (x < y) b = i;
    end
    return b;
  endfunction

  task automatic run(input int s, input bit poke, input bit restart);
    int exp_w;
    settle = CW'(s);
    exp_w = best_idx();
    @(negedge clk); start = 1'b1; ncmp = 0;
    @(negedge clk); start = 1'b0;
    chk(sel_a == 0 && sel_b == 1 && !swap_b, "R1 run start slots",
        int'(sel_a) * 10 + int'(sel_b), 1);
    if (restart) chk(!done, "R10 done cleared on restart", done, 0);
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
    chk(done, "R7 run finished", done, 1);
    chk(int'(winner) == exp_w, poke ? "R8 R6 winner after mid-run start" : "R6 winner",
        winner, exp_w);
    repeat (5) @(negedge clk);
    chk(int'(winner) == exp_w && sel_a == winner, "R1 winner held", winner, exp_w);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    off = '{9, -4, 7, -12, 2, -6, 11, 5};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(winner == 0 && !done && !swap_b && sel_a == 0 && sel_b == 0,
        "R9 reset state", int'(winner) + int'(done), 0);
    run(2, 0, 0);
    off = '{-3, 8, -5, 6, 10, -7, 4, 1};
    run(0, 0, 1);
    off = '{1, -9, 5, -6, 3, 12, -8, 4};
    run(5, 1, 1);
    off = '{6, -11, 9, -2, -5, 7, 13, -4};
    run(1, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule